// File: doc/BRIEF.md
# Radix-4 Carry-Save Modular Multiplier

This block computes the product of two operands reduced by a modulus, R = A·B mod M, for wide operands (256 bits by default). It scans the multiplier A two bits at a time from the most significant end. Each step shifts a redundant accumulator left by two places, adds a table-selected multiple of B, and folds the bits that overflowed the operand width back in as a stored residue. Reduction therefore happens on every step and does not wait for the full product. The accumulator is kept as separate sum and carry words, built from three-input XOR and majority slices, so no carry ripples across the word until the last step.

An operation begins with a one-cycle `start` pulse while the block is idle. The block first fills two small tables. One holds 0, B, 2B and 3B. The other holds k·2^WIDTH mod M for every overflow value k the accumulator can produce. It then runs WIDTH/2 iterations. It merges sum and carry once, folds the remaining overflow, and subtracts M until the value is canonical. `done` pulses for one cycle with the residue on `result`. The modulus must have its most significant bit set, both operands must be below M, and WIDTH must be even and at least 4.

Top module: `r4_modmul`

## Requirements
- R1: When `done` is high, `result` equals (A·B) mod M for the A, B and M sampled at the accepted start, and is below M.
- R2: `done` is high for exactly one cycle per operation, and `busy` is low in that cycle.
- R3: A `start` pulse while `busy` is high is ignored: the running operation completes with its original operands and no second `done` follows.
- R4: `result` keeps its value from one `done` until the next `done`, whatever the inputs do in between.
- R5: `opA`, `opB` and `opM` are sampled only at the edge that accepts `start`; changing them later has no effect on the result.
- R6: `done` is high no later than the (WIDTH/2+36)th rising edge after the edge that accepts `start`.
- R7: While `rst_n` is low, `busy`, `done` and `result` are all zero.
- R8: Edge operands give the canonical residue: a zero operand gives 0, and A = B = M-1 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken only while idle |
| opA | input | WIDTH | Multiplier operand, below opM |
| opB | input | WIDTH | Multiplicand operand, below opM |
| opM | input | WIDTH | Modulus, most significant bit set |
| busy | output | 1 | High from the cycle after an accepted start until done |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | WIDTH | Canonical residue, held until the next done |

## Verification
The hardest case to reach from the ports is the end of the operation. The overflow fold can leave a value between 2M and 3M, and two correction subtractions are then needed before `done`. Small-modulus products with operands near M-1 create that case most often. The bench therefore runs an 8-bit configuration. It sweeps every modulus in a spread of normalised values against operands at 0, 1, 2, M/2, M-2 and M-1, then adds over a thousand random triples. The ignored start and the late operand changes are injected mid-run on a subset of operations. After each of those, the bench watches for a stray second `done`.

// File: rtl/r4mm_pkg.sv
package r4mm_pkg;
  // Overflow residue table depth: the accumulator overflow above WIDTH after
  // the radix-4 shift never reaches 24, so 32 entries cover it.
  localparam int RED_DEPTH = 32;
  localparam int RED_IW    = $clog2(RED_DEPTH);

  typedef enum logic [2:0] {
    StIdle, StFill, StIter, StMerge, StFold, StCorr
  } state_e;

  typedef struct packed {
    logic load;
    logic fill;
    logic iter;
    logic merge;
    logic fold;
    logic corr;
  } strobe_t;
endpackage

// File: rtl/r4mm_csa.sv
module r4mm_csa #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] m
);
  // Bit slices: sum is XOR3, carry is majority (unshifted; caller weights it).
  for (genvar i = 0; i < W; i++) begin : g_slice
    assign s[i] = x[i] ^ y[i] ^ z[i];
    assign m[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
  end
endmodule

// File: rtl/r4mm_ctrl.sv
module r4mm_ctrl
  import r4mm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              geM,
  output strobe_t           stb,
  output logic [RED_IW-1:0] fillIdx,
  output logic              busy,
  output logic              done
);
  localparam int ITERS = WIDTH / 2;
  localparam int IW    = $clog2(ITERS + 1);

  state_e        state;
  logic [IW-1:0] iterCnt;

  always_comb begin
    stb       = '0;
    stb.load  = (state == StIdle) && start;
    stb.fill  = (state == StFill);
    stb.iter  = (state == StIter);
    stb.merge = (state == StMerge);
    stb.fold  = (state == StFold);
    stb.corr  = (state == StCorr);
  end

  assign busy = (state != StIdle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= StIdle;
      fillIdx <= '0;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        StIdle: if (start) begin
          state   <= StFill;
          fillIdx <= RED_IW'(1);
        end
        StFill: begin
          if (fillIdx == RED_IW'(RED_DEPTH - 1)) begin
            state   <= StIter;
            iterCnt <= '0;
          end else begin
            fillIdx <= fillIdx + 1'b1;
          end
        end
        StIter: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == IW'(ITERS - 1)) state <= StMerge;
        end
        StMerge: state <= StFold;
        StFold:  state <= StCorr;
        StCorr: if (!geM) begin
          state <= StIdle;
          done  <= 1'b1;
        end
        default: state <= StIdle;
      endcase
    end
  end
endmodule

// File: rtl/r4mm_dp.sv
module r4mm_dp
  import r4mm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [RED_IW-1:0] fillIdx,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [WIDTH-1:0]  opM,
  output logic              geM,
  output logic [WIDTH-1:0]  result
);
  localparam int AW = WIDTH + 3;   // accumulator: value stays below 6*2^WIDTH
  localparam int HW = AW - WIDTH + 2; // overflow field after the shift by two

  logic [WIDTH-1:0] aReg, bReg, mReg, rVal;
  logic [WIDTH-1:0] redTab [RED_DEPTH];
  logic [WIDTH+1:0] mulTab [4];
  logic [AW-1:0]    sumQ, carQ, finQ;

  // Table fill: redTab[k] = (redTab[k-1] + 2^WIDTH mod M) mod M
  logic [WIDTH:0]   tSum;
  logic [WIDTH-1:0] redNext;
  logic [1:0]       mIdx;
  assign tSum    = {1'b0, redTab[fillIdx - 1'b1]} + {1'b0, rVal};
  assign redNext = WIDTH'((tSum >= {1'b0, mReg}) ? (tSum - {1'b0, mReg}) : tSum);
  assign mIdx    = fillIdx[1:0];

  // Iteration: split shifted sum/carry into overflow field and low word
  logic [HW-1:0]    hiIdx;
  logic [WIDTH-1:0] loS, loC;
  logic [1:0]       digit;
  logic [AW-1:0]    s1, m1, c1, s2, m2, c2;
  assign hiIdx = sumQ[AW-1:WIDTH-2] + carQ[AW-1:WIDTH-2];
  assign loS   = {sumQ[WIDTH-3:0], 2'b00};
  assign loC   = {carQ[WIDTH-3:0], 2'b00};
  assign digit = aReg[WIDTH-1:WIDTH-2];

  r4mm_csa #(.W(AW)) u_csaRed (
    .x(AW'(loS)), .y(AW'(loC)), .z(AW'(redTab[hiIdx])), .s(s1), .m(m1)
  );
  assign c1 = AW'({m1, 1'b0});

  r4mm_csa #(.W(AW)) u_csaMul (
    .x(s1), .y(c1), .z(AW'(mulTab[digit])), .s(s2), .m(m2)
  );
  assign c2 = AW'({m2, 1'b0});

  assign geM = (finQ >= AW'(mReg));

  always_ff @(posedge clk) begin
    if (stb.load) begin
      aReg      <= opA;
      bReg      <= opB;
      mReg      <= opM;
      rVal      <= '0 - opM;
      redTab[0] <= '0;
      mulTab[0] <= '0;
      sumQ      <= '0;
      carQ      <= '0;
    end
    if (stb.fill) begin
      redTab[fillIdx] <= redNext;
      if (fillIdx < RED_IW'(4))
        mulTab[mIdx] <= mulTab[mIdx - 2'd1] + (WIDTH+2)'(bReg);
    end
    if (stb.iter) begin
      sumQ <= s2;
      carQ <= c2;
      aReg <= {aReg[WIDTH-3:0], 2'b00};
    end
    if (stb.merge) finQ <= sumQ + carQ;
    if (stb.fold)
      finQ <= AW'(redTab[RED_IW'(finQ[AW-1:WIDTH])]) + AW'(finQ[WIDTH-1:0]);
    if (stb.corr && geM) finQ <= finQ - AW'(mReg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                result <= '0;
    else if (stb.corr && !geM) result <= finQ[WIDTH-1:0];
  end
endmodule

// File: rtl/r4_modmul.sv
module r4_modmul
  import r4mm_pkg::*;
#(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opM,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  strobe_t           stb;
  logic [RED_IW-1:0] fillIdx;
  logic              geM;

  r4mm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .geM(geM),
    .stb(stb), .fillIdx(fillIdx), .busy(busy), .done(done)
  );

  r4mm_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .fillIdx(fillIdx),
    .opA(opA), .opB(opB), .opM(opM), .geM(geM), .result(result)
  );
endmodule

// File: rtl/r4mm_chk.sv
module r4mm_chk #(
  parameter int WIDTH = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] opM,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);
  localparam int LAT_LIMIT = WIDTH / 2 + 36;

  logic [WIDTH-1:0] mCap;
  logic [15:0]      latCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCap   <= '0;
      latCnt <= '0;
    end else if (start && !busy) begin
      mCap   <= opM;
      latCnt <= 16'd1;
    end else if (busy) begin
      latCnt <= latCnt + 16'd1;
    end
  end

  // R1: residue is canonical against the captured modulus
  assert_result_canon_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < mCap));

  // R2: done is a single-cycle pulse while idle
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3: once busy, the block leaves busy only by finishing
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R4: result moves only together with done
  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R6: bounded latency, counted here rather than with a long delay
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (latCnt <= 16'(LAT_LIMIT)));
endmodule

bind r4_modmul r4mm_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opM(opM),
  .busy(busy), .done(done), .result(result)
);

// File: tb/r4_modmul_tb.sv
module r4_modmul_tb;
  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_MAX    = W / 2 + 37;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] opA = '0, opB = '0, opM = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int nVec = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  r4_modmul #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opA(opA), .opB(opB),
    .opM(opM), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runOp(input int a, input int b, input int m, input bit disturb);
    int  expv;
    int  cyc;
    bit  seen;
    expv = (a * b) % m;
    @(negedge clk);
    opA   = W'(a);
    opB   = W'(b);
    opM   = W'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc   = 1;
    while (!done && cyc < LAT_MAX + 5) begin
      if (disturb && cyc == 3) begin      // R5: late operand change
        opA = ~opA;
        opB = W'(b + 7);
        opM = opM ^ W'(8'h35);
      end
      if (disturb && cyc == 6) start = 1'b1;  // R3: start while busy
      if (disturb && cyc == 7) start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R6 done seen", int'(done), 1);
    chk(cyc <= LAT_MAX, "R6 latency", cyc, LAT_MAX);
    if (a == 0 || b == 0 || (a == m - 1 && b == m - 1))
      chk(int'(result) == expv, "R8 edge operand residue", int'(result), expv);
    else if (disturb)
      chk(int'(result) == expv, "R5 result uses sampled operands", int'(result), expv);
    else
      chk(int'(result) == expv, "R1 residue", int'(result), expv);
    chk(busy == 1'b0, "R2 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R2 done single cycle", int'(done), 0);
    if (disturb) begin
      seen = 1'b0;
      opA  = W'(m - 1);
      opB  = W'(m - 1);
      for (int i = 0; i < LAT_MAX + 10; i++) begin
        @(negedge clk);
        seen |= done;
      end
      chk(!seen, "R3 ignored start launched nothing", int'(seen), 0);
      chk(int'(result) == expv, "R4 result held", int'(result), expv);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nBad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    int mods [8];
    int ops  [6];
    mods = '{128, 129, 170, 193, 200, 251, 254, 255};
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R7 busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R7 done in reset", int'(done), 0);
    chk(result == '0, "R7 result in reset", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (mods[k]) begin
      int m;
      m   = mods[k];
      ops = '{0, 1, 2, m / 2, m - 2, m - 1};
      foreach (ops[i])
        foreach (ops[j])
          runOp(ops[i], ops[j], m, 1'b0);
    end

    for (int n = 0; n < 1200; n++) begin
      int m, a, b;
      m = 128 + int'($urandom % 128);
      a = int'($urandom % m);
      b = int'($urandom % m);
      runOp(a, b, m, n < 20);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule